// File: doc/BRIEF.md
# TLB Programming Register Bank

This block holds four banks of special registers. Software uses them to load a small TLB that it manages itself. Banks 0 and 3 are ordinary register files. Banks 1 and 2 each belong to a memory management unit, and each of these two banks owns its own translation array. The array has 4 sets of 16 entries, and every entry holds a 32-bit hi word and a 32-bit lo word.

Software never addresses an entry directly. It first chooses the entry through a select register. It then stages the hi word: a write to the hi register also copies the value into a cause register. Finally it writes the lo register, and that write stores the new lo word together with the staged cause value as the entry's hi word. When an entry is replaced, the block sends a single-cycle flush request carrying the old virtual page number, so a translation cache elsewhere can drop it. Reads work in the other direction. Any read in an MMU bank first copies the selected entry into the hi and lo mirror registers, then returns the requested register one cycle later.

Top module: `mmu_tlb_regbank`

## Requirements
- R1: After reset every special register in all four banks, every translation entry, `rd_data`, `rd_valid` and `flush_valid` read as zero.
- R2: In banks 0 and 3 every register number, including 3, 4, 5 and 6, is a plain storage register. A write there never raises `flush_valid` and never changes register 3 of that bank.
- R3: A write to register 6 (hi mirror) in bank 1 or 2 also stores the same data in register 3 (cause) of that bank.
- R4: Register 4 of an MMU bank selects the entry: bits [5:4] give the set and bits [3:0] give the index within the set. The other bits are ignored for selection.
- R5: A write to register 5 (lo mirror) in bank 1 or 2 stores the written data as the selected entry's lo word and the bank's current register 3 value as its hi word.
- R6: In the cycle after such a register-5 write, `flush_valid` is high for exactly one cycle. `flush_page` then equals bits [31:13] of the entry's previous hi word, and `flush_was_valid` equals bit 3 of its previous lo word.
- R7: A read in bank 1 or 2, of any register, loads registers 5 and 6 of that bank with the selected entry's lo and hi words. The returned value reflects that refresh.
- R8: Banks 1 and 2 have separate translation arrays and separate registers. Programming one bank leaves the other unchanged.
- R9: `rd_valid` is high in exactly the cycle after a cycle with `rd_en`, and `rd_data` is valid then.
- R10: When a read and a write happen in the same cycle, the read returns the state from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_bank | input | 2 | Bank of the write |
| wr_reg | input | 4 | Register number of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_bank | input | 2 | Bank of the read |
| rd_reg | input | 4 | Register number of the read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data, held until the next read |
| flush_valid | output | 1 | One-cycle flush request |
| flush_page | output | 19 | Virtual page of the replaced entry |
| flush_was_valid | output | 1 | Valid bit of the replaced entry |

## Verification
The bench targets the following corner cases:

- **Stale-mirror reads.** It writes junk into the hi mirror and then reads it back. A design that skipped the refresh would return the junk instead of the entry's hi word.
- **Flush contents.** On replacement it checks the flush page and the old valid bit. A design that took them from the new words would report the page being installed rather than the one being evicted.
- **Entry selection.** It uses select values that differ only in the set bits, and it programs both MMU banks with the same select value. Swapped fields or a shared array would then show up as aliased entries.
- **Plain banks.** Writes to registers 5 and 6 in banks 0 and 3 must raise no flush and must not touch register 3.
- **Same-cycle access.** A read that coincides with a write must return the old value.

// File: rtl/mmu_tlb_regbank.sv
module mmu_tlb_regbank #(
  parameter int W        = 32,
  parameter int RA       = 4,
  parameter int SETB     = 2,
  parameter int IDXB     = 4,
  parameter int PAGE_LSB = 13,
  parameter int VBIT     = 3,
  parameter int R_CAUSE  = 3,
  parameter int R_SEL    = 4,
  parameter int R_LO     = 5,
  parameter int R_HI     = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_bank,
  input  logic [RA-1:0]         wr_reg,
  input  logic [W-1:0]          wr_data,
  input  logic                  rd_en,
  input  logic [1:0]            rd_bank,
  input  logic [RA-1:0]         rd_reg,
  output logic                  rd_valid,
  output logic [W-1:0]          rd_data,
  output logic                  flush_valid,
  output logic [W-PAGE_LSB-1:0] flush_page,
  output logic                  flush_was_valid
);
  localparam int NREG = 1 << RA;
  localparam int EB   = SETB + IDXB;
  localparam int NENT = 1 << EB;

  logic [W-1:0] sreg   [4][NREG];
  logic [W-1:0] tlb_hi [2][NENT];
  logic [W-1:0] tlb_lo [2][NENT];

  // Banks 1 (01) and 2 (10) are the MMU banks; bit 1 picks the array.
  logic          w_mmu, r_mmu, w_t, r_t;
  logic [EB-1:0] w_ent, r_ent;
  logic [W-1:0]  old_hi, old_lo, r_hi, r_lo, r_val;

  assign w_mmu  = wr_bank[0] ^ wr_bank[1];
  assign r_mmu  = rd_bank[0] ^ rd_bank[1];
  assign w_t    = wr_bank[1];
  assign r_t    = rd_bank[1];
  assign w_ent  = sreg[wr_bank][R_SEL][EB-1:0];
  assign r_ent  = sreg[rd_bank][R_SEL][EB-1:0];
  assign old_hi = tlb_hi[w_t][w_ent];
  assign old_lo = tlb_lo[w_t][w_ent];
  assign r_hi   = tlb_hi[r_t][r_ent];
  assign r_lo   = tlb_lo[r_t][r_ent];

  always_comb begin
    r_val = sreg[rd_bank][rd_reg];
    if (r_mmu && rd_reg == RA'(R_LO)) r_val = r_lo;
    if (r_mmu && rd_reg == RA'(R_HI)) r_val = r_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < NREG; r++) sreg[b][r] <= '0;
      for (int t = 0; t < 2; t++)
        for (int e = 0; e < NENT; e++) begin
          tlb_hi[t][e] <= '0;
          tlb_lo[t][e] <= '0;
        end
      rd_valid        <= 1'b0;
      rd_data         <= '0;
      flush_valid     <= 1'b0;
      flush_page      <= '0;
      flush_was_valid <= 1'b0;
    end else begin
      rd_valid    <= rd_en;
      flush_valid <= 1'b0;
      if (rd_en) begin
        rd_data <= r_val;
        if (r_mmu) begin
          sreg[rd_bank][R_LO] <= r_lo;
          sreg[rd_bank][R_HI] <= r_hi;
        end
      end
      if (wr_en) begin
        sreg[wr_bank][wr_reg] <= wr_data;
        if (w_mmu && wr_reg == RA'(R_HI))
          sreg[wr_bank][R_CAUSE] <= wr_data;
        if (w_mmu && wr_reg == RA'(R_LO)) begin
          tlb_lo[w_t][w_ent] <= wr_data;
          tlb_hi[w_t][w_ent] <= sreg[wr_bank][R_CAUSE];
          flush_valid        <= 1'b1;
          flush_page         <= old_hi[W-1:PAGE_LSB];
          flush_was_valid    <= old_lo[VBIT];
        end
      end
    end
  end

  assert_flush_follows_lo_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(wr_en && w_mmu && wr_reg == RA'(R_LO)));

  assert_plain_bank_no_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_mmu) |=> !flush_valid);

  assert_hi_copies_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_mmu && wr_reg == RA'(R_HI)) |=> sreg[$past(wr_bank)][R_CAUSE] == $past(wr_data));

  assert_lo_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_mmu && wr_reg == RA'(R_LO)) |=> tlb_lo[$past(w_t)][$past(w_ent)] == $past(wr_data));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/mmu_tlb_regbank_test.sv
`timescale 1ns/1ps
module mmu_tlb_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [1:0]  wr_bank, rd_bank;
  logic [3:0]  wr_reg, rd_reg;
  logic [31:0] wr_data;
  logic        rd_valid, flush_valid, flush_was_valid;
  logic [31:0] rd_data;
  logic [18:0] flush_page;

  always #10 clk = ~clk;

  mmu_tlb_regbank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_reg(wr_reg),
    .wr_data(wr_data), .rd_en(rd_en), .rd_bank(rd_bank), .rd_reg(rd_reg),
    .rd_valid(rd_valid), .rd_data(rd_data), .flush_valid(flush_valid),
    .flush_page(flush_page), .flush_was_valid(flush_was_valid));

  logic [31:0] m_sreg [4][16];
  logic [31:0] m_hi   [2][64];
  logic [31:0] m_lo   [2][64];
  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_mmu(input logic [1:0] b);
    return b == 2'd1 || b == 2'd2;
  endfunction

  task automatic wr(input logic [1:0] b, input logic [3:0] r, input logic [31:0] d);
    logic       t = b[1];
    logic [5:0] e = m_sreg[b][4][5:0];
    bit         f = is_mmu(b) && r == 4'd5;
    logic [18:0] pg = m_hi[t][e][31:13];
    logic        v  = m_lo[t][e][3];
    m_sreg[b][r] = d;
    if (is_mmu(b) && r == 4'd6) m_sreg[b][3] = d;
    if (f) begin
      m_lo[t][e] = d;
      m_hi[t][e] = m_sreg[b][3];
    end
    @(negedge clk);
    wr_en = 1'b1; wr_bank = b; wr_reg = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!is_mmu(b)) check("R2 plain bank flush", {31'd0, flush_valid}, 32'd0);
    else check("R6 flush strobe", {31'd0, flush_valid}, {31'd0, f});
    if (f) begin
      check("R6 flush page", {13'd0, flush_page}, {13'd0, pg});
      check("R6 flush old valid", {31'd0, flush_was_valid}, {31'd0, v});
    end
  endtask

  task automatic rd(input string req, input logic [1:0] b, input logic [3:0] r);
    logic       t = b[1];
    logic [5:0] e = m_sreg[b][4][5:0];
    if (is_mmu(b)) begin
      m_sreg[b][5] = m_lo[t][e];
      m_sreg[b][6] = m_hi[t][e];
    end
    @(negedge clk);
    rd_en = 1'b1; rd_bank = b; rd_reg = r;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 read valid", {31'd0, rd_valid}, 32'd1);
    check(req, rd_data, m_sreg[b][r]);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h5EED1);
    for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) m_sreg[b][r] = '0;
    for (int t = 0; t < 2; t++) for (int e = 0; e < 64; e++) begin m_hi[t][e] = '0; m_lo[t][e] = '0; end
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_bank = '0; wr_reg = '0; wr_data = '0; rd_bank = '0; rd_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'd0);
    check("R1 reset rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 reset flush", {31'd0, flush_valid}, 32'd0);
    rd("R1 reset bank0 reg", 2'd0, 4'd7);
    @(negedge clk);
    check("R9 valid drops", {31'd0, rd_valid}, 32'd0);
    rd("R1 reset entry hi", 2'd2, 4'd6);

    wr(2'd0, 4'd9, 32'hA5A5_0001);
    rd("R2 plain readback", 2'd0, 4'd9);
    wr(2'd3, 4'd6, 32'h1111_2222);
    wr(2'd3, 4'd5, 32'h3333_4444);
    rd("R2 cause untouched", 2'd3, 4'd3);
    rd("R2 plain reg5", 2'd3, 4'd5);

    wr(2'd1, 4'd6, 32'hDEAD_E000);
    rd("R3 cause copy", 2'd1, 4'd3);

    wr(2'd1, 4'd4, 32'hFFFF_FF25);
    wr(2'd1, 4'd5, 32'h0000_0ABF);
    wr(2'd1, 4'd4, 32'h0000_0015);
    rd("R4 other set empty", 2'd1, 4'd6);
    wr(2'd1, 4'd4, 32'h0000_0025);
    rd("R5 entry hi", 2'd1, 4'd6);
    rd("R5 entry lo", 2'd1, 4'd5);
    wr(2'd1, 4'd6, 32'h1234_5000);
    wr(2'd1, 4'd5, 32'h0000_0000);
    wr(2'd1, 4'd5, 32'h0000_0008);

    wr(2'd2, 4'd4, 32'h0000_0025);
    rd("R8 bank2 array separate", 2'd2, 4'd6);
    rd("R8 bank2 cause separate", 2'd2, 4'd3);

    wr(2'd1, 4'd6, 32'hBADB_AD00);
    rd("R7 mirror refreshed", 2'd1, 4'd6);
    rd("R7 other reg read", 2'd1, 4'd3);
    rd("R7 lo mirror after read", 2'd1, 4'd5);

    wr(2'd0, 4'd2, 32'h0000_0077);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'd0; wr_reg = 4'd2; wr_data = 32'h0000_0099;
    rd_en = 1'b1; rd_bank = 2'd0; rd_reg = 4'd2;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R10 read sees old", rd_data, 32'h0000_0077);
    m_sreg[0][2] = 32'h0000_0099;
    rd("R10 write applied", 2'd0, 4'd2);

    for (int i = 0; i < 800; i++) begin
      logic [1:0] b = 2'($urandom_range(0, 3));
      logic [3:0] r = 4'($urandom_range(2, 7));
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 1) == 0) wr(b, r, d);
      else rd("R7 random read", b, r);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule